// File: doc/BRIEF.md
# Serial CRC-16 Framer and Checker

This block computes a 16-bit cyclic redundancy check one bit at a time. The register is built in distributed-XOR form, so each XOR gate sits between two neighbouring flops. The polynomial is x^16 + x^15 + x^2 + 1. The block handles whole frames. A frame opens with a one-cycle start strobe, which also picks the direction for the whole frame.

In the sending direction, payload bits pass straight through to the serial output while the check value builds up. The last payload bit carries an end-of-payload strobe. The 16 bit times that follow are placeholder positions, whose input bits are ignored. In those positions the block sends the accumulated check value, most significant bit first.

In the receiving direction, the block runs the same division over the payload and the 16 received check bits. It reports an error whenever the final remainder is not zero. In both directions a one-cycle done pulse closes the frame, and the error flag is meaningful only together with that pulse. Bits advance only in cycles where the input valid is high, so the serial stream may contain gaps of any length.

Top module: `crc16_serial_framer`

## Requirements
- R1: During and directly after synchronous active-low reset, `done`, `crc_error` and `dout_valid` are 0 and the check register holds zero.
- R2: For each accepted bit, let f = `din` XOR register bit 15. The register shifts up one place with f entering bit 0, and f is also XORed into the values that land in bits 2 and 15. The result is the MSB-first CRC with polynomial 0x8005 and initial value zero.
- R3: A cycle with `sof`=1 clears the register and starts a frame. `rx_mode` is sampled only in that cycle (1 = receive, 0 = send). The bit offered in that cycle is not taken, and later changes of `rx_mode` inside the frame have no effect.
- R4: A cycle with `din_valid`=0 inside a frame changes nothing and gives `dout_valid`=0.
- R5: Every accepted payload bit, and every accepted bit in receive mode, appears on `dout` in the same cycle with `dout_valid`=1.
- R6: In send mode, the 16 accepted bits after the one marked by `eop` leave `dout` as the check value, MSB first, and their `din` values are ignored.
- R7: In receive mode, `crc_error` is 1 exactly when the remainder over payload plus the 16 trailer bits is not zero. Any single flipped bit therefore sets it.
- R8: `done` rises for exactly one cycle, in the cycle after the 16th trailer bit is accepted. `crc_error` is 0 whenever `done` is 0, and it is always 0 for a sent frame.
- R9: A `sof` in the same cycle as `done` starts the next frame without changing the `done` and `crc_error` values reported in that cycle.
- R10: Outside a frame, `din_valid` and `eop` are ignored: `dout_valid` and `done` stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_mode | input | 1 | Direction, sampled with `sof`: 1 receive, 0 send |
| sof | input | 1 | Start-of-frame strobe, clears the register |
| eop | input | 1 | Marks the last payload bit, qualified by `din_valid` |
| din | input | 1 | Serial data in |
| din_valid | input | 1 | `din` carries a bit this cycle |
| dout | output | 1 | Serial data out (payload, then check value when sending) |
| dout_valid | output | 1 | A frame bit is being accepted this cycle |
| done | output | 1 | One-cycle end-of-frame pulse |
| crc_error | output | 1 | Nonzero remainder in receive mode, valid with `done` |

## Verification
Two functions can fall in the same cycle: the closing `done` and error report of one frame, and the `sof` of the next frame. The bench chains frames by raising `sof` in the cycle where `done` is expected. It judges that cycle by comparing `done` and `crc_error` with the model's verdict for the earlier frame. The following frame, which starts from that same `sof`, must still yield a correct check value or verdict.

// File: rtl/crc16_frame_pkg.sv
// Shared types for the serial CRC framer.
// Assumes: nothing beyond standard SystemVerilog.
package crc16_frame_pkg;
    // Frame phase: waiting, payload bits, 16 trailer bits.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BODY  = 2'd1,
        PH_CHECK = 2'd2
    } phase_e;
endpackage

// File: rtl/crc16_galois_reg.sv
// Distributed-XOR CRC register. Each step shifts up one place. When use_fb
// is high, the feedback (din XOR MSB) is XORed into every bit where POLY has
// a 1. When use_fb is low, the register shifts plainly with zero fill.
// Assumes: POLY[0] is 1; clear has priority over step.
module crc16_galois_reg #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    POLY = 16'h8005
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic         use_fb,
    input  logic         din,
    output logic [W-1:0] crc_q,
    output logic [W-1:0] crc_nxt
);
    logic         fb;
    logic [W-1:0] fb_vec;
    logic [W-1:0] stepped;

    // Feedback bit from the incoming data and the top of the register.
    assign fb = din ^ crc_q[W-1];

    // Tap vector: feedback lands only where the polynomial has a term.
    for (genvar i = 0; i < W; i++) begin : g_tap
        if (POLY[i]) begin : g_on
            assign fb_vec[i] = fb & use_fb;
        end else begin : g_off
            assign fb_vec[i] = 1'b0;
        end
    end

    // Next register value for a step, cleared value, or hold.
    always_comb begin
        stepped = {crc_q[W-2:0], 1'b0} ^ fb_vec;
        if (clear)      crc_nxt = '0;
        else if (step)  crc_nxt = stepped;
        else            crc_nxt = crc_q;
    end

    // Register update.
    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_nxt;
    end

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (crc_q == '0));                                   // R3
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !step) |=> $stable(crc_q));                      // R4
endmodule

// File: rtl/crc16_frame_ctrl.sv
// Frame sequencer. It tracks idle, payload and trailer phases, latches the
// direction at start of frame, and counts the 16 trailer bits.
// Assumes: eop is only meaningful on an accepted payload bit; sof wins
// over everything else in its cycle.
module crc16_frame_ctrl
    import crc16_frame_pkg::*;
#(
    parameter int W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_mode,
    input  logic sof,
    input  logic eop,
    input  logic din_valid,
    output logic clear,
    output logic step,
    output logic use_fb,
    output logic tx_trailer,
    output logic last_bit,
    output logic rx_q
);
    localparam int               CNT_W    = $clog2(W) + 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(W - 1);

    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             rx_lat;
    logic             accept;

    // Decode of the current phase into datapath controls.
    always_comb begin
        accept     = din_valid && !sof && (phase != PH_IDLE);
        clear      = sof;
        step       = accept;
        tx_trailer = (phase == PH_CHECK) && !rx_lat;
        use_fb     = !tx_trailer;
        last_bit   = accept && (phase == PH_CHECK) && (cnt == CNT_LAST);
        rx_q       = rx_lat;
    end

    // Phase, trailer counter and direction latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            rx_lat <= 1'b0;
        end else if (sof) begin
            phase  <= PH_BODY;
            cnt    <= '0;
            rx_lat <= rx_mode;
        end else if (accept) begin
            if (phase == PH_BODY) begin
                if (eop) phase <= PH_CHECK;
            end else if (phase == PH_CHECK) begin
                if (cnt == CNT_LAST) begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LAST);                                           // R6
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !sof |=> $stable(rx_lat));                                  // R3
    AST_LAST_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && !sof) |=> (phase == PH_IDLE));                 // R8
endmodule

// File: rtl/crc16_serial_framer.sv
// Serial CRC-16 frame generator and checker. When sending, payload passes
// through and the check value replaces the 16 trailer positions. When
// receiving, payload plus the check bits must leave a zero remainder.
// Assumes: one bit per valid cycle; frames are opened by a sof strobe.
module crc16_serial_framer #(
    parameter int           W    = 16,
    parameter logic [W-1:0] POLY = 16'h8005
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_mode,
    input  logic sof,
    input  logic eop,
    input  logic din,
    input  logic din_valid,
    output logic dout,
    output logic dout_valid,
    output logic done,
    output logic crc_error
);
    logic         clear, step, use_fb, tx_trailer, last_bit, rx_q;
    logic [W-1:0] crc_q, crc_nxt;
    logic         done_q, err_q;

    crc16_frame_ctrl #(.W(W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_mode    (rx_mode),
        .sof        (sof),
        .eop        (eop),
        .din_valid  (din_valid),
        .clear      (clear),
        .step       (step),
        .use_fb     (use_fb),
        .tx_trailer (tx_trailer),
        .last_bit   (last_bit),
        .rx_q       (rx_q)
    );

    crc16_galois_reg #(.W(W), .POLY(POLY)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .step    (step),
        .use_fb  (use_fb),
        .din     (din),
        .crc_q   (crc_q),
        .crc_nxt (crc_nxt)
    );

    // Serial output: check value MSB in the send trailer, else pass-through.
    assign dout       = tx_trailer ? crc_q[W-1] : din;
    assign dout_valid = step;
    assign done       = done_q;
    assign crc_error  = err_q;

    // End-of-frame report, judged on the remainder after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= last_bit;
            err_q  <= last_bit && rx_q && (crc_nxt != '0);
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                            // R8
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        crc_error |-> done);                                        // R8
    AST_TX_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rx_q) |-> !crc_error);                            // R8
    AST_NO_OUT_ON_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> !dout_valid);                                       // R3
endmodule

// File: tb/tb_crc16_serial_framer.sv
`timescale 1ns/1ps
module tb_crc16_serial_framer;
    logic clk = 1'b0;
    logic rst_n, rx_mode, sof, eop, din, din_valid;
    logic dout, dout_valid, done, crc_error;

    int checks = 0;
    int errors = 0;
    bit frame_q[$];
    bit base_q[$];
    bit cap_q[$];
    bit next_rx;

    always #2.5 clk = ~clk;

    crc16_serial_framer dut (
        .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .sof(sof), .eop(eop),
        .din(din), .din_valid(din_valid), .dout(dout),
        .dout_valid(dout_valid), .done(done), .crc_error(crc_error)
    );

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Textbook bitwise CRC over the first n bits of frame_q.
    function automatic logic [15:0] model_crc(input int n);
        logic [15:0] r = 16'h0000;
        for (int i = 0; i < n; i++) begin
            bit f = frame_q[i] ^ r[15];
            r = r << 1;
            if (f) r = r ^ 16'h8005;
        end
        return r;
    endfunction

    // Drive one frame from frame_q (npay payload bits + 16 trailer bits).
    task automatic run_frame(input bit rx, input int npay, input bit chain_in,
                             input bit chain_out, input int gap_pct);
        logic [15:0] exp_crc;
        bit          exp_err;
        bit          exp_out;
        exp_crc = model_crc(npay);
        exp_err = rx ? (model_crc(npay + 16) != 16'h0) : 1'b0;
        cap_q.delete();
        if (!chain_in) begin
            @(negedge clk);
            sof = 1; rx_mode = rx; din_valid = 1'($urandom);
            din = 1'($urandom); eop = 1'($urandom);
            #1 chk("R3 sof bit discarded", dout_valid, 0);
        end
        for (int i = 0; i < npay + 16; i++) begin
            while (int'($urandom % 100) < gap_pct) begin
                @(negedge clk);
                sof = 0; din_valid = 0; din = 1'($urandom);
                eop = 1'($urandom); rx_mode = 1'($urandom);
                #1 chk("R4 gap", dout_valid, 0);
            end
            @(negedge clk);
            sof = 0; rx_mode = 1'($urandom); din_valid = 1;
            eop = (i == npay - 1);
            din = (i >= npay && !rx) ? 1'($urandom) : frame_q[i];
            #1;
            exp_out = (i >= npay && !rx) ? exp_crc[15 - (i - npay)] : din;
            chk("R5 dout_valid", dout_valid, 1);
            if (i >= npay && !rx) chk("R6 R2 trailer bit", dout, exp_out);
            else                  chk("R5 pass-through", dout, exp_out);
            chk("R8 no early done", done, 0);
            cap_q.push_back(dout);
        end
        @(negedge clk);
        din_valid = 0; eop = 0; sof = chain_out; rx_mode = next_rx;
        #1;
        chk(chain_out ? "R9 R8 done with sof" : "R8 done", done, 1);
        chk(rx ? "R7 R2 verdict" : "R8 tx no error", crc_error, exp_err);
        if (!chain_out) begin
            @(negedge clk);
            sof = 0;
            #1 chk("R8 single pulse", done, 0);
            chk("R8 error low without done", crc_error, 0);
        end
    endtask

    task automatic fill_payload(input int n);
        frame_q.delete();
        for (int i = 0; i < n; i++) frame_q.push_back(1'($urandom));
        for (int i = 0; i < 16; i++) frame_q.push_back(1'b0);
    endtask

    task automatic seal_payload(input int n);
        logic [15:0] c;
        c = model_crc(n);
        for (int i = 0; i < 16; i++) frame_q[n + i] = c[15 - i];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        rst_n = 0; rx_mode = 0; sof = 0; eop = 0; din = 0; din_valid = 1;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 done in reset", done, 0);
        chk("R1 error in reset", crc_error, 0);
        @(negedge clk);
        rst_n = 1; din_valid = 0;
        #1 chk("R1 dout_valid after reset", dout_valid, 0);

        // Idle: valid and eop outside any frame.
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            din_valid = 1; eop = 1'($urandom); din = 1'($urandom);
            #1 chk("R10 idle valid", dout_valid, 0);
            chk("R10 idle done", done, 0);
        end
        @(negedge clk);
        din_valid = 0; eop = 0;
        #1 chk("R10 idle done after", done, 0);

        // Reset state of the register: a zero payload must give zero CRC.
        fill_payload(8);
        for (int i = 0; i < 8; i++) frame_q[i] = 1'b0;
        run_frame(0, 8, 0, 0, 0);

        // Send frames, then loop each captured stream back as a receive.
        for (int f = 0; f < 10; f++) begin
            n = (f == 0) ? 1 : 1 + int'($urandom % 40);
            fill_payload(n);
            run_frame(0, n, 0, 0, (f % 2) ? 30 : 0);
            frame_q = cap_q;
            run_frame(1, n, 0, 0, (f % 3) ? 0 : 25);
        end

        // Every single-bit corruption must be flagged.
        fill_payload(24);
        seal_payload(24);
        base_q = frame_q;
        for (int k = 0; k < 40; k++) begin
            frame_q = base_q;
            frame_q[k] = ~frame_q[k];
            run_frame(1, 24, 0, 0, 10);
        end

        // Arbitrary received frames judged by the model.
        for (int f = 0; f < 10; f++) begin
            n = 1 + int'($urandom % 30);
            fill_payload(n);
            for (int i = n; i < n + 16; i++) frame_q[i] = 1'($urandom);
            run_frame(1, n, 0, 0, 15);
        end

        // Back-to-back: sof in the done cycle.
        fill_payload(12);
        next_rx = 1;
        run_frame(0, 12, 0, 1, 0);
        frame_q = cap_q;
        next_rx = 0;
        run_frame(1, 12, 1, 1, 20);
        fill_payload(5);
        run_frame(0, 5, 1, 0, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule